// File: doc/BRIEF.md
# Control Port and Pin Mapper

This block is a small configuration register file reached through a multiplexed 10-bit address/data port. Every access takes two strobes on a slow access clock, qualified by an active-low select and a read/write line. The first strobe carries the register address and the second carries the data. For a read, the block drives the addressed register back onto the bus. The whole block runs on one fast system clock. The access clock is sampled in that clock, and each of its rising edges counts as one strobe.

The block also holds eight pin configuration registers, one for each bit of an 8-bit bidirectional general-purpose port. Each register chooses the direction of its pin and a 5-bit function code. An output pin carries a status bit or a control bit. An input pin writes its level into a control bit or into a pin-only latch bit. The block refuses any configuration that gives a function a direction it does not support. A test-enable register of four bits returns to all ones whenever it is read.

Top module: `ctlport_pinmap`

## Requirements
- R1: A write takes two rising access-clock edges, both with `port_sel_n` low. At the first edge `port_rnw` is low and `ad_in` is latched as the address. At the second edge `ad_in` is written into that register. `ad_oe` is low after a write.
- R2: A read is the same sequence with `port_rnw` high at the first edge. From the second edge on, `ad_oe` is high and `ad_out` holds the register, zero-extended. The bus stays driven until the next access-clock edge or until `port_sel_n` goes high.
- R3: While `port_sel_n` is high, access-clock edges are ignored, the sequence returns to the address phase and `ad_oe` is low.
- R4: Pin i has a configuration register at address 0x0F+i. Bit 5 sets the direction (1 = input, 0 = output) and bits 4:0 hold the function code. `gpio_oe[i]` is the inverse of bit 5. The register reads back as written.
- R5: Function codes 0-7 select status bit `stat_in[c]` and are output-only. Codes 8-15 select bit c-8 of the control register at 0x01 and work in both directions. Codes 16-23 select bit c-16 of the pin latch register at 0x02 (output `latch_out`) and are input-only. Codes 24-31 select nothing.
- R6: A configuration write whose direction is not legal for its code is ignored. The pin keeps its previous direction and function.
- R7: An output pin drives the value of its selected bit, one system clock after that value is taken up. An input pin drives 0.
- R8: Each clock, an input pin writes its level into its selected bit. When a port write to 0x01 falls in the same cycle, the pin has priority for that bit.
- R9: The test register at 0x55 holds four enables, bit 0 to bit 3 (`test_en`): scrambler, NRZI, LSB clipping and sync detect. It resets to 0xF and writes set or clear each bit. A read returns the current value, and the register then becomes 0xF.
- R10: After reset, pin 4 is an output of code 4 (lock detect) and pin 6 is an output of code 6 (self-test pass, 1 = pass). Every other pin i is an input on code 16+i. The control register and the latch register are 0 and `ad_oe` is low.
- R11: Address 0x00 reads `stat_in` and ignores writes. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| acc_clk | input | 1 | Access strobe; each rising edge is one phase |
| port_sel_n | input | 1 | Active-low control-port select |
| port_rnw | input | 1 | 1 = read, 0 = write; sampled in the address phase |
| ad_in | input | 10 | Address/data bus in |
| ad_out | output | 10 | Read data |
| ad_oe | output | 1 | Bus drive enable for read data |
| stat_in | input | 8 | Internal status bits (4 = lock, 6 = self-test pass) |
| gpio_in | input | 8 | Sampled levels of the I/O pins |
| gpio_out | output | 8 | Values driven on the I/O pins |
| gpio_oe | output | 8 | Per-pin output enable |
| ctrl_out | output | 8 | Control register |
| latch_out | output | 8 | Pin-only latch bits |
| test_en | output | 4 | Test-mode enables |

## Verification
The hardest case to reach is a strobe sequence broken halfway by the select. The bench issues a lone address strobe, raises the select for a few cycles, and then runs a full write to the test register. If the phase was not cleared, that write would land in the control register instead, and both registers are checked to tell the cases apart. A second hard case is a same-cycle collision between a port write and a pin input on one control bit. It is reached by first mapping an input pin onto that bit and holding the pin high through the write.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
    localparam int ADW   = 10;
    localparam int NPIN  = 8;
    localparam int FW    = 5;
    localparam int GRP   = 8;
    localparam int IDXW  = $clog2(GRP);
    localparam int GW    = FW - IDXW;
    localparam int CFGW  = FW + 1;
    localparam int TESTW = 4;

    localparam logic [ADW-1:0] A_STAT  = 10'h000;
    localparam logic [ADW-1:0] A_CTRL  = 10'h001;
    localparam logic [ADW-1:0] A_LATCH = 10'h002;
    localparam logic [ADW-1:0] A_CFG0  = 10'h00F;
    localparam logic [ADW-1:0] A_TEST  = 10'h055;

    localparam logic [GW-1:0] G_STAT  = 2'd0;
    localparam logic [GW-1:0] G_CTRL  = 2'd1;
    localparam logic [GW-1:0] G_LATCH = 2'd2;

    localparam logic DIR_OUT = 1'b0;
    localparam logic DIR_IN  = 1'b1;

    localparam int PIN_LOCK = 4;
    localparam int PIN_BIST = 6;

    typedef enum logic {PH_ADDR, PH_DATA} phase_e;

    typedef struct packed {
        logic          dir;
        logic [FW-1:0] code;
    } pincfg_t;

    function automatic logic cfg_legal(pincfg_t c);
        logic [GW-1:0] g;
        g = c.code[FW-1:IDXW];
        if (c.dir == DIR_OUT) return (g == G_STAT) || (g == G_CTRL);
        return (g == G_CTRL) || (g == G_LATCH);
    endfunction

    function automatic pincfg_t cfg_default(int pin);
        pincfg_t c;
        if (pin == PIN_LOCK || pin == PIN_BIST) begin
            c.dir  = DIR_OUT;
            c.code = {G_STAT, IDXW'(pin)};
        end else begin
            c.dir  = DIR_IN;
            c.code = {G_LATCH, IDXW'(pin)};
        end
        return c;
    endfunction
endpackage

// File: rtl/ctlport_seq.sv
module ctlport_seq
    import ctlport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_clk,
    input  logic           sel_n,
    input  logic           rnw,
    input  logic [ADW-1:0] ad_in,
    input  logic [ADW-1:0] rd_val,
    output logic           acc_wr,
    output logic           acc_rd,
    output logic [ADW-1:0] acc_addr,
    output logic [ADW-1:0] acc_wdata,
    output logic [ADW-1:0] ad_out,
    output logic           ad_oe
);
    typedef struct packed {
        logic           aclk_p;
        phase_e         phase;
        logic           rnw;
        logic [ADW-1:0] addr;
        logic [ADW-1:0] dout;
        logic           oe;
    } seq_t;

    seq_t q, d;
    logic strobe;

    always_comb begin
        d      = q;
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        strobe = acc_clk & ~q.aclk_p;
        d.aclk_p = acc_clk;
        if (sel_n) begin
            d.phase = PH_ADDR;
            d.oe    = 1'b0;
        end else if (strobe) begin
            if (q.phase == PH_ADDR) begin
                d.addr  = ad_in;
                d.rnw   = rnw;
                d.phase = PH_DATA;
                d.oe    = 1'b0;
            end else begin
                d.phase = PH_ADDR;
                if (q.rnw) begin
                    acc_rd = 1'b1;
                    d.dout = rd_val;
                    d.oe   = 1'b1;
                end else begin
                    acc_wr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{aclk_p: 1'b0, phase: PH_ADDR, rnw: 1'b0,
                   addr: '0, dout: '0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign acc_addr  = q.addr;
    assign acc_wdata = ad_in;
    assign ad_out    = q.dout;
    assign ad_oe     = q.oe;
endmodule

// File: rtl/ctlport_pincfg.sv
module ctlport_pincfg
    import ctlport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_wr,
    input  logic [ADW-1:0]           acc_addr,
    input  logic [CFGW-1:0]          wdata,
    output pincfg_t [NPIN-1:0]       cfg
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam logic [ADW-1:0] MY_ADDR = A_CFG0 + ADW'(i);
        pincfg_t cfg_d, cfg_q;
        logic    hit;

        always_comb begin
            cfg_d = cfg_q;
            hit   = acc_wr && (acc_addr == MY_ADDR);
            if (hit && cfg_legal(pincfg_t'(wdata))) begin
                cfg_d = pincfg_t'(wdata);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q <= cfg_default(i);
            else        cfg_q <= cfg_d;
        end

        assign cfg[i] = cfg_q;
    end
endmodule

// File: rtl/ctlport_regs.sv
module ctlport_regs
    import ctlport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic [ADW-1:0]      acc_addr,
    input  logic [ADW-1:0]      acc_wdata,
    input  pincfg_t [NPIN-1:0]  cfg,
    input  logic [GRP-1:0]      stat_in,
    input  logic [NPIN-1:0]     gpio_in,
    output logic [ADW-1:0]      rd_val,
    output logic [GRP-1:0]      ctrl_o,
    output logic [GRP-1:0]      latch_o,
    output logic [TESTW-1:0]    test_o,
    output logic [NPIN-1:0]     gpio_out
);
    typedef struct packed {
        logic [GRP-1:0]   ctrl;
        logic [GRP-1:0]   latch;
        logic [TESTW-1:0] test;
        logic [NPIN-1:0]  gout;
    } regs_t;

    regs_t q, d;
    logic  unused_hi;

    assign unused_hi = ^acc_wdata[ADW-1:GRP];

    always_comb begin
        logic [GW-1:0]   grp;
        logic [IDXW-1:0] idx;
        d = q;
        if (acc_wr && acc_addr == A_CTRL) d.ctrl = acc_wdata[GRP-1:0];
        if (acc_wr && acc_addr == A_TEST) d.test = acc_wdata[TESTW-1:0];
        if (acc_rd && acc_addr == A_TEST) d.test = '1;
        for (int i = 0; i < NPIN; i++) begin
            grp = cfg[i].code[FW-1:IDXW];
            idx = cfg[i].code[IDXW-1:0];
            d.gout[i] = 1'b0;
            if (cfg[i].dir == DIR_IN) begin
                if (grp == G_CTRL)       d.ctrl[idx]  = gpio_in[i];
                else if (grp == G_LATCH) d.latch[idx] = gpio_in[i];
            end else begin
                if (grp == G_STAT)      d.gout[i] = stat_in[idx];
                else if (grp == G_CTRL) d.gout[i] = q.ctrl[idx];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (acc_addr == A_STAT)       rd_val = ADW'(stat_in);
        else if (acc_addr == A_CTRL)  rd_val = ADW'(q.ctrl);
        else if (acc_addr == A_LATCH) rd_val = ADW'(q.latch);
        else if (acc_addr == A_TEST)  rd_val = ADW'(q.test);
        for (int i = 0; i < NPIN; i++) begin
            if (acc_addr == A_CFG0 + ADW'(i)) rd_val = ADW'(cfg[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: '0, latch: '0, test: '1, gout: '0};
        end else begin
            q <= d;
        end
    end

    assign ctrl_o   = q.ctrl;
    assign latch_o  = q.latch;
    assign test_o   = q.test;
    assign gpio_out = q.gout;
endmodule

// File: rtl/ctlport_pinmap.sv
module ctlport_pinmap
    import ctlport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_clk,
    input  logic             port_sel_n,
    input  logic             port_rnw,
    input  logic [9:0]       ad_in,
    output logic [9:0]       ad_out,
    output logic             ad_oe,
    input  logic [7:0]       stat_in,
    input  logic [7:0]       gpio_in,
    output logic [7:0]       gpio_out,
    output logic [7:0]       gpio_oe,
    output logic [7:0]       ctrl_out,
    output logic [7:0]       latch_out,
    output logic [3:0]       test_en
);
    logic                acc_wr, acc_rd;
    logic [ADW-1:0]      acc_addr, acc_wdata, rd_val;
    pincfg_t [NPIN-1:0]  cfg;

    ctlport_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_clk  (acc_clk),
        .sel_n    (port_sel_n),
        .rnw      (port_rnw),
        .ad_in    (ad_in),
        .rd_val   (rd_val),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe)
    );

    ctlport_pincfg u_pincfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .wdata    (acc_wdata[CFGW-1:0]),
        .cfg      (cfg)
    );

    ctlport_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .cfg      (cfg),
        .stat_in  (stat_in),
        .gpio_in  (gpio_in),
        .rd_val   (rd_val),
        .ctrl_o   (ctrl_out),
        .latch_o  (latch_out),
        .test_o   (test_en),
        .gpio_out (gpio_out)
    );

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            gpio_oe[i] = (cfg[i].dir == DIR_OUT);
        end
    end
endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk
    import ctlport_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             acc_wr,
    input logic             acc_rd,
    input logic [ADW-1:0]   acc_addr,
    input logic [ADW-1:0]   acc_wdata,
    input logic             ad_oe,
    input logic [NPIN-1:0]  gpio_oe,
    input logic [TESTW-1:0] test_en
);
    logic cfg_hit, cfg_bad;
    assign cfg_hit = (acc_addr >= A_CFG0) && (acc_addr < A_CFG0 + ADW'(NPIN));
    assign cfg_bad = !cfg_legal(pincfg_t'(acc_wdata[CFGW-1:0]));

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !ad_oe);                                   // R1
    AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !sel_n) |=> ad_oe);                        // R2
    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !ad_oe);                                    // R3
    AST_BAD_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && cfg_hit && cfg_bad) |=> $stable(gpio_oe)); // R6
    AST_TEST_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == A_TEST) |=> (test_en == '1));  // R9
    AST_NO_PHASE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && acc_rd));                                 // R1
endmodule

bind ctlport_pinmap ctlport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (port_sel_n),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .ad_oe    (ad_oe),
    .gpio_oe  (gpio_oe),
    .test_en  (test_en)
);

// File: tb/tb_ctlport_pinmap.sv
module tb_ctlport_pinmap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_clk = 1'b0;
    logic       port_sel_n = 1'b1;
    logic       port_rnw = 1'b0;
    logic [9:0] ad_in = '0;
    logic [9:0] ad_out;
    logic       ad_oe;
    logic [7:0] stat_in = '0;
    logic [7:0] gpio_in = '0;
    logic [7:0] gpio_out, gpio_oe, ctrl_out, latch_out;
    logic [3:0] test_en;

    int nchk = 0;
    int nfail = 0;
    logic [9:0] rv;

    always #2.5 clk = ~clk;

    ctlport_pinmap dut (
        .clk(clk), .rst_n(rst_n), .acc_clk(acc_clk), .port_sel_n(port_sel_n),
        .port_rnw(port_rnw), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .stat_in(stat_in), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .ctrl_out(ctrl_out), .latch_out(latch_out),
        .test_en(test_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic toggle(input logic [9:0] v);
        @(negedge clk);
        ad_in   = v;
        acc_clk = 1'b1;
        @(negedge clk);
        acc_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [9:0] v);
        port_sel_n = 1'b0;
        port_rnw   = 1'b0;
        toggle(a);
        toggle(v);
    endtask

    task automatic rd(input logic [9:0] a, output logic [9:0] v);
        port_sel_n = 1'b0;
        port_rnw   = 1'b1;
        toggle(a);
        port_rnw   = 1'b0;
        toggle(10'h000);
        v = ad_out;
    endtask

    task automatic t_reset();
        chk("R10 oe", gpio_oe, 8'h50);
        chk("R10 test", test_en, 4'hF);
        chk("R10 ad_oe", ad_oe, 1'b0);
        chk("R10 ctrl", ctrl_out, 8'h00);
        chk("R10 latch", latch_out, 8'h00);
    endtask

    task automatic t_default_map();
        stat_in = 8'h50; settle();
        chk("R10 R7 lock/bist out", gpio_out, 8'h50);
        stat_in = 8'h10; settle();
        chk("R10 R7 bist fail", gpio_out, 8'h10);
        stat_in = 8'h00; settle();
        rd(10'h013, rv);
        chk("R10 pin4 cfg", rv, 10'h004);
    endtask

    task automatic t_write_read();
        wr(10'h001, 10'h0A5);
        chk("R1 ctrl write", ctrl_out, 8'hA5);
        chk("R1 no drive", ad_oe, 1'b0);
        rd(10'h001, rv);
        chk("R2 read data", rv, 10'h0A5);
        chk("R2 drive", ad_oe, 1'b1);
        settle();
        chk("R2 hold", ad_oe, 1'b1);
        port_sel_n = 1'b1; settle();
        chk("R3 release", ad_oe, 1'b0);
    endtask

    task automatic t_select();
        port_sel_n = 1'b1;
        toggle(10'h001);
        toggle(10'h3FF);
        chk("R3 ignored", ctrl_out, 8'hA5);
        port_sel_n = 1'b0;
        port_rnw = 1'b0;
        toggle(10'h001);
        port_sel_n = 1'b1; settle();
        wr(10'h055, 10'h000);
        chk("R3 phase reset test", test_en, 4'h0);
        chk("R3 phase reset ctrl", ctrl_out, 8'hA5);
    endtask

    task automatic t_test_reg();
        wr(10'h055, 10'h005);
        chk("R9 write", test_en, 4'h5);
        rd(10'h055, rv);
        chk("R9 read old", rv, 10'h005);
        chk("R9 read sets", test_en, 4'hF);
        rd(10'h055, rv);
        chk("R9 reread", rv, 10'h00F);
        wr(10'h055, 10'h00A);
        rd(10'h055, rv);
        chk("R9 read A", rv, 10'h00A);
        chk("R9 sets again", test_en, 4'hF);
    endtask

    task automatic t_cfg_out();
        wr(10'h00F, 10'h009);
        chk("R4 oe", gpio_oe, 8'h51);
        chk("R7 ctrl bit1 low", gpio_out[0], 1'b0);
        wr(10'h001, 10'h002);
        chk("R7 ctrl bit1 high", gpio_out[0], 1'b1);
        rd(10'h00F, rv);
        chk("R4 readback", rv, 10'h009);
        wr(10'h012, 10'h005);
        chk("R5 pin3 out", gpio_oe, 8'h59);
        stat_in = 8'h20; settle();
        chk("R5 status5 high", gpio_out[3], 1'b1);
        stat_in = 8'h00; settle();
        chk("R5 status5 low", gpio_out[3], 1'b0);
    endtask

    task automatic t_cfg_illegal();
        wr(10'h00F, 10'h011);
        rd(10'h00F, rv);
        chk("R6 out latch code", rv, 10'h009);
        chk("R6 oe kept", gpio_oe, 8'h59);
        wr(10'h010, 10'h023);
        rd(10'h010, rv);
        chk("R6 in status code", rv, 10'h031);
        wr(10'h00F, 10'h019);
        rd(10'h00F, rv);
        chk("R6 out none code", rv, 10'h009);
        wr(10'h010, 10'h039);
        rd(10'h010, rv);
        chk("R6 in none code", rv, 10'h031);
        chk("R6 oe final", gpio_oe, 8'h59);
    endtask

    task automatic t_cfg_in();
        gpio_in = 8'h03; settle();
        chk("R8 latch bit1", latch_out, 8'h02);
        chk("R7 input pin drives 0", gpio_out[1], 1'b0);
        rd(10'h002, rv);
        chk("R5 latch read", rv, 10'h002);
        gpio_in = 8'h00; settle();
        chk("R8 latch follows", latch_out, 8'h00);
        wr(10'h011, 10'h02C);
        gpio_in = 8'h04; settle();
        chk("R8 ctrl bit4 from pin", ctrl_out, 8'h12);
        wr(10'h001, 10'h000);
        chk("R8 pin wins", ctrl_out, 8'h10);
        gpio_in = 8'h00; settle();
        chk("R8 ctrl bit4 low", ctrl_out, 8'h00);
    endtask

    task automatic t_status();
        stat_in = 8'h3C;
        rd(10'h000, rv);
        chk("R11 status read", rv, 10'h03C);
        wr(10'h000, 10'h3FF);
        rd(10'h000, rv);
        chk("R11 status ro", rv, 10'h03C);
        rd(10'h030, rv);
        chk("R11 unmapped zero", rv, 10'h000);
        wr(10'h030, 10'h3FF);
        chk("R11 unmapped ctrl", ctrl_out, 8'h00);
        chk("R11 unmapped test", test_en, 4'hF);
        chk("R11 unmapped latch", latch_out, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_default_map();
        t_write_read();
        t_select();
        t_test_reg();
        t_cfg_out();
        t_cfg_illegal();
        t_cfg_in();
        t_status();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule